// File: doc/BRIEF.md
# Immediate logical execute unit

This unit is the execute stage for the record-form AND-with-immediate operations of a 64-bit integer pipeline. Each accepted instruction word is decoded into its opcode, source index, destination index and 16-bit unsigned immediate. The source register value is then masked by the immediate in one of two ways. One form places the immediate in the upper half of the low 32-bit word. The other leaves the immediate in the low 16 bits. Each result is written back to the register file.

Every legal operation also updates condition field 0. Its less-than, greater-than and equal flags come from a signed compare of the low 32 bits of the result against zero. Its fourth flag is a copy of the incoming summary-overflow bit. Any opcode that is neither form is flagged as illegal, and it blocks both the register write and the condition update.

The register file read happens upstream, so the source value arrives alongside the instruction word. All outputs are registered, and they appear one cycle after a valid strobe.

Top module: `imm_logic_exec`

## Requirements
- R1: Fields use big-endian bit numbering. The opcode is `instr[31:26]`. `instr[25:21]` is the source index. `instr[20:16]` is the destination index and is driven on `dst_idx`. `instr[15:0]` is the unsigned immediate.
- R2: Opcode 29 (shifted form) yields `result = {32'b0, src_val[31:16] & imm, 16'b0}`. The upper 32 bits and the low 16 bits of the result are always zero.
- R3: Opcode 28 (plain form) yields `result = {48'b0, src_val[15:0] & imm}`.
- R4: `cr0[3]` is LT, `cr0[2]` is GT and `cr0[1]` is EQ. They come from a signed compare with zero of `result[31:0]`: a set bit 31 means LT, an all-zero word means EQ, and anything else means GT. Exactly one of the three is set on a legal operation.
- R5: `cr0[0]` equals the `so_in` value sampled with the instruction.
- R6: A legal opcode (28 or 29) sets `rf_we`=1, `cr_we`=1 and `illegal`=0.
- R7: Any other opcode sets `rf_we`=0, `cr_we`=0 and `illegal`=1. It also drives `result`=0 and `cr0`=0.
- R8: Outputs are captured on the rising edge when `in_valid` is high. `out_valid` is high for exactly the following cycle. While `in_valid` is low, `out_valid` drops and the other outputs hold their last values.
- R9: Synchronous active-high `rst` clears `out_valid` and all other outputs to zero, and it overrides a simultaneous `in_valid`.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source register value |
| so_in | input | 1 | Summary-overflow bit |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Masked result |
| cr0 | output | 4 | Condition nibble {LT, GT, EQ, SO} |
| cr_we | output | 1 | Condition field 0 write enable |
| rf_we | output | 1 | Register write enable |
| dst_idx | output | 5 | Destination register index |
| illegal | output | 1 | Unrecognized opcode |

## Verification
**Sign of the shifted result.** A shifted mask of 0x8000 over an all-ones source must give exactly bit 31 and an LT classification. A design that compared the full 64-bit value would report GT, and one that skipped the shift would put the bit at position 15.

**Mask boundaries.** All-ones sources test whether the upper word and the low half leak through. A zero immediate tests for EQ.

**Opcode neighbours and field swaps.** Opcodes 27, 30, 31 and 0 must suppress both write enables. Distinct source and destination indices catch a design that swapped the two fields.

**Traffic and reset.** Back-to-back and gapped traffic checks that results are never dropped, duplicated or altered while idle. A reset together with a valid strobe must leave nothing visible.

// File: rtl/imm_logic_pkg.sv
package imm_logic_pkg;

  typedef enum logic [1:0] {
    OPK_ILLEGAL = 2'd0,
    OPK_SHIFTED = 2'd1,
    OPK_PLAIN   = 2'd2
  } op_kind_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_nibble_t;

endpackage

// File: rtl/imm_logic_decode.sv
module imm_logic_decode
  import imm_logic_pkg::*;
#(
  parameter int INSTR_W     = 32,
  parameter int OPC_W       = 6,
  parameter int REG_W       = 5,
  parameter int IMM_W       = 16,
  parameter int OP_SHIFTED  = 29,
  parameter int OP_PLAIN    = 28
) (
  input  logic [INSTR_W-1:0] instr,
  output op_kind_e           kind,
  output logic [REG_W-1:0]   dst_idx,
  output logic [IMM_W-1:0]   imm
);
  // Big-endian numbering: field 0 is the most significant.
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int SRC_LSB = OPC_LSB - REG_W;
  localparam int DST_LSB = SRC_LSB - REG_W;

  logic [OPC_W-1:0] opcode;
  logic [REG_W-1:0] unused_src_idx;

  assign opcode         = instr[INSTR_W-1:OPC_LSB];
  assign unused_src_idx = instr[OPC_LSB-1:SRC_LSB];
  assign dst_idx        = instr[SRC_LSB-1:DST_LSB];
  assign imm            = instr[IMM_W-1:0];

  always_comb begin
    if (opcode == OPC_W'(OP_SHIFTED))     kind = OPK_SHIFTED;
    else if (opcode == OPC_W'(OP_PLAIN))  kind = OPK_PLAIN;
    else                                  kind = OPK_ILLEGAL;
  end

endmodule

// File: rtl/imm_logic_mask.sv
module imm_logic_mask #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [WORD_W-1:0] src_lo,
  input  logic [IMM_W-1:0]  imm,
  input  logic              shifted,
  output logic [XLEN-1:0]   res
);
  localparam int HI_LSB = WORD_W - IMM_W;

  logic [IMM_W-1:0] lo_and;
  logic [IMM_W-1:0] hi_and;

  for (genvar g = 0; g < IMM_W; g++) begin : g_bit
    assign lo_and[g] = src_lo[g] & imm[g];
    assign hi_and[g] = src_lo[g + HI_LSB] & imm[g];
  end

  always_comb begin
    res = '0;
    if (shifted) res[WORD_W-1:HI_LSB] = hi_and;
    else         res[IMM_W-1:0]       = lo_and;
  end

endmodule

// File: rtl/imm_logic_cr.sv
module imm_logic_cr
  import imm_logic_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              so,
  output cr_nibble_t        cr
);
  logic neg;
  logic zero;

  assign neg  = word[WORD_W-1];
  assign zero = (word == '0);

  always_comb begin
    cr.lt = neg;
    cr.eq = zero;
    cr.gt = !neg && !zero;
    cr.so = so;
  end

endmodule

// File: rtl/imm_logic_exec.sv
module imm_logic_exec
  import imm_logic_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int INSTR_W    = 32,
  parameter int OPC_W      = 6,
  parameter int REG_W      = 5,
  parameter int IMM_W      = 16,
  parameter int OP_SHIFTED = 29,
  parameter int OP_PLAIN   = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    src_val,
  input  logic               so_in,
  output logic               out_valid,
  output logic [XLEN-1:0]    result,
  output logic [3:0]         cr0,
  output logic               cr_we,
  output logic               rf_we,
  output logic [REG_W-1:0]   dst_idx,
  output logic               illegal
);
  localparam int WORD_W = 2 * IMM_W;

  op_kind_e          kind;
  logic [REG_W-1:0]  dec_dst;
  logic [IMM_W-1:0]  dec_imm;
  logic [XLEN-1:0]   mask_res;
  cr_nibble_t        cr_next;
  logic              legal;
  logic [XLEN-WORD_W-1:0] unused_src_hi;

  assign unused_src_hi = src_val[XLEN-1:WORD_W];

  imm_logic_decode #(
    .INSTR_W(INSTR_W), .OPC_W(OPC_W), .REG_W(REG_W), .IMM_W(IMM_W),
    .OP_SHIFTED(OP_SHIFTED), .OP_PLAIN(OP_PLAIN)
  ) u_dec (
    .instr   (instr),
    .kind    (kind),
    .dst_idx (dec_dst),
    .imm     (dec_imm)
  );

  imm_logic_mask #(.XLEN(XLEN), .WORD_W(WORD_W), .IMM_W(IMM_W)) u_mask (
    .src_lo  (src_val[WORD_W-1:0]),
    .imm     (dec_imm),
    .shifted (kind == OPK_SHIFTED),
    .res     (mask_res)
  );

  imm_logic_cr #(.WORD_W(WORD_W)) u_cr (
    .word (mask_res[WORD_W-1:0]),
    .so   (so_in),
    .cr   (cr_next)
  );

  assign legal = (kind != OPK_ILLEGAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      cr0       <= '0;
      cr_we     <= 1'b0;
      rf_we     <= 1'b0;
      dst_idx   <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= legal ? mask_res : '0;
        cr0     <= legal ? cr_next : 4'b0000;
        cr_we   <= legal;
        rf_we   <= legal;
        illegal <= !legal;
        dst_idx <= dec_dst;
      end
    end
  end

endmodule

// File: rtl/imm_logic_exec_chk.sv
module imm_logic_exec_chk #(
  parameter int XLEN    = 64,
  parameter int INSTR_W = 32,
  parameter int REG_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               so_in,
  input logic               out_valid,
  input logic [XLEN-1:0]    result,
  input logic [3:0]         cr0,
  input logic               cr_we,
  input logic               rf_we,
  input logic               illegal
);

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drops_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> result[XLEN-1:32] == '0);

  p_shift_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd29) |=> result[15:0] == 16'h0000);

  p_plain_width_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd28) |=> result[XLEN-1:16] == '0);

  p_one_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cr_we) |-> $countones(cr0[3:1]) == 1);

  p_so_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (instr[31:26] == 6'd28 || instr[31:26] == 6'd29))
      |=> cr0[0] == $past(so_in));

  p_legal_we_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (rf_we == cr_we) && (rf_we != illegal));

  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0) && (cr0 == 4'b0000));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> !out_valid && !rf_we && !cr_we);

endmodule

bind imm_logic_exec imm_logic_exec_chk #(.XLEN(XLEN), .INSTR_W(INSTR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .so_in(so_in),
  .out_valid(out_valid), .result(result), .cr0(cr0), .cr_we(cr_we),
  .rf_we(rf_we), .illegal(illegal)
);

// File: tb/imm_logic_exec_tb.sv
module imm_logic_exec_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_val = '0;
  logic        so_in = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic [3:0]  cr0;
  logic        cr_we;
  logic        rf_we;
  logic [4:0]  dst_idx;
  logic        illegal;

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_logic_exec u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_val(src_val), .so_in(so_in), .out_valid(out_valid),
    .result(result), .cr0(cr0), .cr_we(cr_we), .rf_we(rf_we),
    .dst_idx(dst_idx), .illegal(illegal)
  );

  typedef struct {
    logic [63:0] res;
    logic [3:0]  cr;
    logic        we;
    logic        ill;
    logic [4:0]  dst;
    string       rtag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last;
  bit   have_last = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [5:0] op, input logic [4:0] ra,
                                 input logic [15:0] imm, input logic [63:0] src,
                                 input logic so);
    exp_t e;
    logic [31:0] w;
    e.dst = ra;
    if (op == 6'd29) begin
      e.res = {32'h0, src[31:16] & imm, 16'h0};
      e.rtag = "R2";
    end else if (op == 6'd28) begin
      e.res = {48'h0, src[15:0] & imm};
      e.rtag = "R3";
    end else begin
      e.res = '0;
      e.rtag = "R7";
    end
    w = e.res[31:0];
    if (op == 6'd28 || op == 6'd29) begin
      e.cr  = {w[31], (!w[31] && w != 0), (w == 0), so};
      e.we  = 1'b1;
      e.ill = 1'b0;
    end else begin
      e.cr  = 4'b0000;
      e.we  = 1'b0;
      e.ill = 1'b1;
    end
    return e;
  endfunction

  task automatic send(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] ra,
                      input logic [15:0] imm, input logic [63:0] src, input logic so);
    @(negedge clk);
    instr    = {op, rs, ra, imm};
    src_val  = src;
    so_in    = so;
    in_valid = 1'b1;
    exp_q.push_back(model(op, ra, imm, src, so));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      instr    = 32'hFFFF_FFFF;
      src_val  = 64'hDEAD_BEEF_CAFE_F00D;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_valid) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected out_valid", 64'd1, 64'd0);
        end else begin
          e = exp_q.pop_front();
          check(result === e.res, e.rtag, result, e.res);
          check(cr0[3:1] === e.cr[3:1], "R4 cr0 LT/GT/EQ", {61'b0, cr0[3:1]}, {61'b0, e.cr[3:1]});
          check(cr0[0] === e.cr[0], "R5 cr0 SO", {63'b0, cr0[0]}, {63'b0, e.cr[0]});
          check(rf_we === e.we && cr_we === e.we && illegal === e.ill,
                e.ill ? "R7 enables" : "R6 enables",
                {61'b0, rf_we, cr_we, illegal}, {61'b0, e.we, e.we, e.ill});
          check(dst_idx === e.dst, "R1 dst_idx", {59'b0, dst_idx}, {59'b0, e.dst});
          last = e;
          have_last = 1;
        end
      end else if (!rst && have_last) begin
        check(result === last.res && dst_idx === last.dst, "R8 hold while idle",
              result, last.res);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr;
    lfsr = 64'h1234_5678_9ABC_DEF1;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 1'b0 && result === 64'h0 && cr0 === 4'h0 && rf_we === 1'b0,
          "R9 reset state", {59'b0, out_valid, rf_we, cr0[2:0]}, 64'h0);
    @(negedge clk);
    rst = 1'b0;

    // Shifted form corners
    send(6'd29, 5'd3, 5'd7, 16'h8000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0); // LT, bit31
    send(6'd29, 5'd4, 5'd9, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1); // upper/low leak
    send(6'd29, 5'd1, 5'd2, 16'h7FFF, 64'h0000_0000_FFFF_FFFF, 1'b0); // GT
    send(6'd29, 5'd5, 5'd6, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1); // EQ
    idle(2);
    // Plain form corners
    send(6'd28, 5'd8, 5'd31, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    send(6'd28, 5'd2, 5'd0, 16'h00F0, 64'h1234_5678_9ABC_DE0F, 1'b1); // EQ
    send(6'd28, 5'd10, 5'd11, 16'h8001, 64'h0000_0000_0000_8000, 1'b1);
    idle(3);
    // Illegal neighbours
    send(6'd27, 5'd1, 5'd1, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    send(6'd30, 5'd1, 5'd2, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    send(6'd31, 5'd1, 5'd3, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    send(6'd0,  5'd1, 5'd4, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    idle(1);

    // Mixed pseudo-random traffic
    for (int i = 0; i < 60; i++) begin
      logic [5:0] op;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 7);
      lfsr = lfsr ^ (lfsr << 17);
      case (lfsr[1:0])
        2'd0, 2'd1: op = 6'd29;
        2'd2:       op = 6'd28;
        default:    op = lfsr[7:2];
      endcase
      send(op, lfsr[12:8], lfsr[20:16], lfsr[47:32], {lfsr[31:0], lfsr[63:32]}, lfsr[3]);
      if (lfsr[5]) idle(1);
    end
    idle(3);
    check(exp_q.size() == 0, "R8 all results delivered", 64'(exp_q.size()), 64'd0);

    // Reset overriding a valid strobe
    @(negedge clk);
    have_last = 0;
    rst      = 1'b1;
    instr    = {6'd29, 5'd1, 5'd2, 16'hFFFF};
    src_val  = 64'hFFFF_FFFF_FFFF_FFFF;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    check(out_valid === 1'b0 && result === 64'h0 && rf_we === 1'b0 && cr_we === 1'b0,
          "R9 reset overrides valid", result, 64'h0);
    rst = 1'b0;
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule